// File: doc/BRIEF.md
# Sticky Masked Interrupt Latch

This block sits between a peripheral controller and a processor interrupt line. It holds a small bank of 32-bit registers, addressed by byte offset, that software uses to see and acknowledge the controller's interrupt. The controller's request comes in on one wire. It is sampled into a read-only raw-input register, at bit 11 (value 0x0000_0800).

Every clock cycle the block ORs the raw input, gated by the mask register, into a status register. A status bit stays set after the input drops, until software writes a 1 to it. Because the status is evaluated every cycle, a clear is followed at once by a fresh latch from the current raw input and mask. A mask write takes effect on the next evaluation. The interrupt output is high while any status bit is set.

Two route registers and a polarity register are stored and read back, but they have no effect on the interrupt logic. A read of any offset that maps to no register returns all ones, and a write to such an offset changes nothing.

Top module: `sticky_irq_latch`

## Requirements
- R1: After reset, every register reads 0 and irq_o is 0. Reset is asynchronous, so irq_o drops while rst_ni is low.
- R2: The registers at offsets 0x08 (route0), 0x0C (route1), 0x54 (mask) and 0x58 (polarity) store a full 32-bit write and return it on a read.
- R3: The raw-input register at 0x5C shows src_irq_i at bit 11 (0x0000_0800) one clock after it is sampled, and shows 0 in all other bits.
- R4: Status (0x50) becomes status OR (raw input AND mask) on every clock. A raw bit whose mask bit is 0 never sets status.
- R5: A status bit stays set after its raw input returns to 0.
- R6: A write to status clears each bit written as 1 and leaves each bit written as 0 unchanged. If raw AND mask is still set for a cleared bit, that bit is set again in the same update.
- R7: When the mask is written while the raw input is high, status latches on the following clock, with no other register access.
- R8: The polarity register has no effect on status or irq_o.
- R9: A write to the raw-input register is ignored, and so is its data.
- R10: A read of an unimplemented offset, including an unaligned one, returns 0xFFFF_FFFF. A write to such an offset changes no register.
- R11: irq_o is high exactly when status is non-zero. It never rises unless raw AND mask was set on the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| src_irq_i | input | 1 | Interrupt request from the peripheral controller |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
The bench builds the block with its default parameters: an 8-bit offset bus and the source at bit 11. With an 8-bit offset bus, every defined offset can be reached, along with unaligned and unmapped offsets next to them. The source bit position is the only one that can ever latch, so the bench checks that the other 31 status bits stay zero after reads and clears. The run covers:
- a clear while the source is still active;
- a mask write while the source is active;
- a reset taken while the interrupt is pending.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int unsigned REG_W = 32;

  localparam logic [7:0] OFS_ROUTE0 = 8'h08;
  localparam logic [7:0] OFS_ROUTE1 = 8'h0C;
  localparam logic [7:0] OFS_STATUS = 8'h50;
  localparam logic [7:0] OFS_MASK   = 8'h54;
  localparam logic [7:0] OFS_POL    = 8'h58;
  localparam logic [7:0] OFS_RAW    = 8'h5C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ROUTE0,
    SEL_ROUTE1,
    SEL_STATUS,
    SEL_MASK,
    SEL_POL,
    SEL_RAW
  } sel_e;
endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
  import sirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o
);
  localparam int unsigned OW = 8;

  function automatic logic hit(logic [ADDR_W-1:0] a, logic [OW-1:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    sel_o = SEL_NONE;
    if      (hit(addr_i, OFS_ROUTE0)) sel_o = SEL_ROUTE0;
    else if (hit(addr_i, OFS_ROUTE1)) sel_o = SEL_ROUTE1;
    else if (hit(addr_i, OFS_STATUS)) sel_o = SEL_STATUS;
    else if (hit(addr_i, OFS_MASK))   sel_o = SEL_MASK;
    else if (hit(addr_i, OFS_POL))    sel_o = SEL_POL;
    else if (hit(addr_i, OFS_RAW))    sel_o = SEL_RAW;
  end
endmodule

// File: rtl/sirq_ctrl_regs.sv
module sirq_ctrl_regs
  import sirq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  sel_e         sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] route0_o,
  output logic [W-1:0] route1_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pol_o
);
  localparam int unsigned NREG = 4;
  localparam sel_e REG_SEL [NREG] = '{SEL_ROUTE0, SEL_ROUTE1, SEL_MASK, SEL_POL};

  logic [W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs_q[g] <= '0;
      else if (wr_i && (sel_i == REG_SEL[g]))  regs_q[g] <= wdata_i;
    end
  end

  assign route0_o = regs_q[0];
  assign route1_o = regs_q[1];
  assign mask_o   = regs_q[2];
  assign pol_o    = regs_q[3];

  // R2: a mask write is visible on the next cycle
  assert_mask_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_MASK) |=> (mask_o == $past(wdata_i)));

  // R10: unmapped writes leave every stored register untouched
  assert_unmapped_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_NONE) |=>
      ($stable(route0_o) && $stable(route1_o) && $stable(mask_o) && $stable(pol_o)));
endmodule

// File: rtl/sirq_status.sv
module sirq_status #(
  parameter int unsigned W       = 32,
  parameter int unsigned SRC_BIT = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         src_irq_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  localparam logic [W-1:0] SRC_MASK = W'(1) << SRC_BIT;

  logic [W-1:0] raw_q;
  logic [W-1:0] status_q;
  logic [W-1:0] pend;

  assign pend = raw_q & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q    <= '0;
      status_q <= '0;
    end else begin
      raw_q    <= src_irq_i ? SRC_MASK : '0;
      // clear first, then re-latch in the same update
      status_q <= (status_q & ~clr_i) | pend;
    end
  end

  assign raw_o    = raw_q;
  assign status_o = status_q;
  assign irq_o    = |status_q;

  // R4: every pending bit is latched on the next edge
  assert_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend != '0) |=> ((status_q & $past(pend)) == $past(pend)));

  // R5: a set bit only drops when written with a one
  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(status_q) & ~$past(clr_i) & ~status_q) == '0));

  // R6: a cleared bit that is not pending goes low
  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~pend) != '0) |=> ((status_q & $past(clr_i & ~pend)) == '0));

  // R11: the interrupt never rises without a pending source
  assert_irq_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(pend) != '0));
endmodule

// File: rtl/sticky_irq_latch.sv
module sticky_irq_latch
  import sirq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned SRC_BIT = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              src_irq_i,
  output logic              irq_o
);
  localparam int unsigned W = REG_W;

  sel_e         sel;
  logic         wr;
  logic [W-1:0] route0, route1, mask, pol, raw, status, clr;

  assign wr  = req_i && we_i;
  assign clr = (wr && sel == SEL_STATUS) ? wdata_i : '0;

  sirq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  sirq_ctrl_regs #(.W(W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .sel_i    (sel),
    .wdata_i  (wdata_i),
    .route0_o (route0),
    .route1_o (route1),
    .mask_o   (mask),
    .pol_o    (pol)
  );

  sirq_status #(.W(W), .SRC_BIT(SRC_BIT)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_irq_i (src_irq_i),
    .mask_i    (mask),
    .clr_i     (clr),
    .raw_o     (raw),
    .status_o  (status),
    .irq_o     (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_ROUTE0: rdata_o = route0;
      SEL_ROUTE1: rdata_o = route1;
      SEL_STATUS: rdata_o = status;
      SEL_MASK:   rdata_o = mask;
      SEL_POL:    rdata_o = pol;
      SEL_RAW:    rdata_o = raw;
      default:    rdata_o = '1;
    endcase
  end

  // R9: a write aimed at the raw register does not disturb the sampled value
  assert_raw_ro_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_RAW && !src_irq_i) |=> (raw == '0));
endmodule

// File: tb/sticky_irq_latch_tb.sv
module sticky_irq_latch_tb;
  localparam int unsigned NV = 38;
  // op: 0 write, 1 read-check, 2 set source, 3 irq-check, 4 idle
  localparam logic [78:0] VEC [NV] = '{
    {4'd1, 3'd1, 8'h50, 32'h0,         32'h0},          // R1 status
    {4'd1, 3'd1, 8'h54, 32'h0,         32'h0},          // R1 mask
    {4'd1, 3'd3, 8'h00, 32'h0,         32'h0},          // R1 irq
    {4'd2, 3'd0, 8'h08, 32'hA5A5_0001, 32'h0},
    {4'd2, 3'd1, 8'h08, 32'h0,         32'hA5A5_0001},  // R2 route0
    {4'd2, 3'd0, 8'h0C, 32'h1234_5678, 32'h0},
    {4'd2, 3'd1, 8'h0C, 32'h0,         32'h1234_5678},  // R2 route1
    {4'd8, 3'd0, 8'h58, 32'hFFFF_FFFF, 32'h0},
    {4'd8, 3'd1, 8'h58, 32'h0,         32'hFFFF_FFFF},  // R8 polarity stored
    {4'd3, 3'd2, 8'h00, 32'h1,         32'h0},
    {4'd3, 3'd4, 8'h00, 32'h0,         32'h0},
    {4'd3, 3'd1, 8'h5C, 32'h0,         32'h0000_0800},  // R3 raw shows bit 11
    {4'd4, 3'd1, 8'h50, 32'h0,         32'h0},          // R4 masked: no latch
    {4'd8, 3'd3, 8'h00, 32'h0,         32'h0},          // R8 polarity does not fire irq
    {4'd2, 3'd0, 8'h54, 32'h0000_0800, 32'h0},
    {4'd7, 3'd4, 8'h00, 32'h0,         32'h0},
    {4'd7, 3'd1, 8'h50, 32'h0,         32'h0000_0800},  // R7 latch after mask write
    {4'd11,3'd3, 8'h00, 32'h0,         32'h1},          // R11 irq high
    {4'd6, 3'd0, 8'h50, 32'h0000_0800, 32'h0},
    {4'd6, 3'd4, 8'h00, 32'h0,         32'h0},
    {4'd6, 3'd1, 8'h50, 32'h0,         32'h0000_0800},  // R6 re-latch while active
    {4'd5, 3'd2, 8'h00, 32'h0,         32'h0},
    {4'd5, 3'd4, 8'h00, 32'h0,         32'h0},
    {4'd3, 3'd1, 8'h5C, 32'h0,         32'h0},          // R3 raw dropped
    {4'd5, 3'd1, 8'h50, 32'h0,         32'h0000_0800},  // R5 sticky
    {4'd6, 3'd0, 8'h50, 32'h0,         32'h0},
    {4'd6, 3'd1, 8'h50, 32'h0,         32'h0000_0800},  // R6 zeros clear nothing
    {4'd6, 3'd0, 8'h50, 32'hFFFF_FFFF, 32'h0},
    {4'd6, 3'd1, 8'h50, 32'h0,         32'h0},          // R6 cleared
    {4'd11,3'd3, 8'h00, 32'h0,         32'h0},          // R11 irq low
    {4'd9, 3'd0, 8'h5C, 32'hFFFF_FFFF, 32'h0},
    {4'd9, 3'd1, 8'h5C, 32'h0,         32'h0},          // R9 raw write ignored
    {4'd9, 3'd1, 8'h50, 32'h0,         32'h0},          // R9 no status side effect
    {4'd10,3'd0, 8'h20, 32'hDEAD_BEEF, 32'h0},
    {4'd10,3'd1, 8'h20, 32'h0,         32'hFFFF_FFFF},  // R10 unmapped read
    {4'd10,3'd1, 8'h54, 32'h0,         32'h0000_0800},  // R10 mask untouched
    {4'd10,3'd1, 8'h4C, 32'h0,         32'hFFFF_FFFF},  // R10
    {4'd10,3'd1, 8'h09, 32'h0,         32'hFFFF_FFFF}   // R10 unaligned
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        src_irq_i = 1'b0;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  sticky_irq_latch u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .src_irq_i, .irq_o
  );

  task automatic check(int req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic rd(int req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 check(req, rdata_o, exp);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=5000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      req_i = 1'b0; we_i = 1'b0;
      addr_i  = VEC[i][71:64];
      wdata_i = VEC[i][63:32];
      case (VEC[i][74:72])
        3'd0: begin req_i = 1'b1; we_i = 1'b1; end
        3'd1: req_i = 1'b1;
        3'd2: src_irq_i = VEC[i][32];
        default: ;
      endcase
      #1;
      if (VEC[i][74:72] == 3'd1) check(int'(VEC[i][78:75]), rdata_o, VEC[i][31:0]);
      if (VEC[i][74:72] == 3'd3) check(int'(VEC[i][78:75]), {31'd0, irq_o}, VEC[i][31:0]);
    end

    // R1: reset taken while the interrupt is pending
    @(negedge clk_i);
    req_i = 1'b0; src_irq_i = 1'b1;
    repeat (2) @(negedge clk_i);
    #1 check(11, {31'd0, irq_o}, 32'h1);            // R11
    rst_ni = 1'b0;
    #1 check(1, {31'd0, irq_o}, 32'h0);             // R1 async
    rd(1, 8'h54, 32'h0);                            // R1 mask cleared
    rd(1, 8'h08, 32'h0);                            // R1 route0 cleared
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    rd(4, 8'h50, 32'h0);                            // R4 mask 0 after reset: no latch
    rd(3, 8'h5C, 32'h0000_0800);                    // R3
    finish_run();
  end
endmodule